// File: doc/BRIEF.md
# Management Serial Register Slave

This block stands in for the management side of an Ethernet PHY. A host toggles a management clock and a data line by software, and the block sees both as plain inputs. On every rising edge of the management clock it clocks one bit into a 32-bit shift word and advances a bit counter. A run of 32 consecutive ones realigns the block, so the next bit is the first bit of a frame.

Frames are decoded at two fixed counts. At the 16th bit a read opcode loads the addressed register into the shift word, which then drives the data-return line. At the 32nd bit a write opcode stores the low half of the word into the addressed register. Only the bits in that register's writable mask change. The block answers one PHY address and holds 32 registers of 16 bits each. A direction input from the host marks the data phase of a read.

The inputs are brought into the system clock domain through a short synchronizer. Edges of the management clock are detected there.

Top module: `mgmt_phy_slave`

## Requirements
- R1: Between rising edges of the management clock, the bit counter, the shift word and the data-return output all hold their values, whatever the data and direction inputs do.
- R2: On each edge the counter is incremented and the word moves left by one. The new low bit is the data input when the new count is below 16 or the direction input is low; otherwise it is 0.
- R3: When the shift word becomes all ones, the counter returns to 0, so the bit that follows is bit 1 of a frame. Any partial frame sent before such a preamble has no lasting effect.
- R4: At count 16, word bits 15:12 hold the opcode, bits 11:7 the PHY address and bits 6:2 the register number. Opcode 6 (0110) replaces the word with the register value, zero-extended. After edges 17 to 31 with direction high, the data-return output therefore shows register bits 14 down to 0, and after edge 32 it shows 0.
- R5: The data-return output is updated only on an edge where the count is 16 or more and the direction input is high; it then takes bit 15 of the shifted word. It is 0 after reset.
- R6: At count 32, word bits 31:28 hold the opcode, bits 27:23 the PHY address, bits 22:18 the register number and bits 15:0 the data. Opcode 5 (0101) is a write.
- R7: Only PHY address 1 responds. A read of any other address returns 0, and a write to any other address leaves all registers unchanged.
- R8: A write changes only the bits set in the register's mask. The masks are: 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25; 0xC01F for register 4; 0x0FFF for register 16; 0x0000 for all others, including register 0.
- R9: After reset, register 0 holds 0x3100, register 1 holds 0xF02C, register 2 holds 0x7810, register 4 holds 0x0501, register 5 holds 0x4181, register 16 holds 0x0003 and register 18 holds 0x0001. All other registers hold 0.
- R10: A frame whose opcode at count 32 is neither 5 nor, at count 16, 6 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management clock from the host |
| mdo_i | input | 1 | Serial data from the host |
| rd_dir_i | input | 1 | High while the host reads the data phase |
| mdi_o | output | 1 | Serial data returned to the host |

## Verification
The assertions assume that the management clock, the data input and the direction input change slowly compared with the system clock. Each level must stay stable for several system cycles, so all three inputs come through the synchronizer in step and each management-clock edge gives exactly one detect pulse. The stimulus holds every level for at least four system cycles before each edge and eight cycles after it. It changes data and direction only while the management clock is low.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_REGS = 32;

  function automatic logic [REG_W-1:0] reg_mask(input int idx);
    logic [REG_W-1:0] m;
    m = '0;
    if (idx == 1 || idx == 2 || idx == 3 || idx == 5 || idx == 6) m = 16'hFFFF;
    else if (idx == 4)                                             m = 16'hC01F;
    else if (idx == 16)                                            m = 16'h0FFF;
    else if (idx >= 18 && idx <= 25)                               m = 16'hFFFF;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] reg_reset(input int idx);
    logic [REG_W-1:0] v;
    case (idx)
      0:       v = 16'h3100;
      1:       v = 16'hF02C;
      2:       v = 16'h7810;
      4:       v = 16'h0501;
      5:       v = 16'h4181;
      16:      v = 16'h0003;
      18:      v = 16'h0001;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/mgmt_edge_sync.sv
module mgmt_edge_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic         rise_o
);
  logic [W-1:0] stage_q [STAGES];
  logic         clk_prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) clk_prev_q <= 1'b0;
    else         clk_prev_q <= stage_q[STAGES-1][0];

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1][0] & ~clk_prev_q;
endmodule

// File: rtl/mgmt_frame_shifter.sv
module mgmt_frame_shifter #(
  parameter int FRAME_W = 32,
  parameter int OP_W    = 4,
  parameter int PHY_W   = 5,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int OP_RD   = 6,
  parameter int OP_WR   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              mdo_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [PHY_W-1:0]  rd_phy_o,
  output logic [ADDR_W-1:0] rd_reg_o,
  output logic              wr_en_o,
  output logic [PHY_W-1:0]  wr_phy_o,
  output logic [ADDR_W-1:0] wr_reg_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mdi_o
);
  localparam int HALF  = FRAME_W / 2;
  localparam int CNT_W = $clog2(FRAME_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(FRAME_W);
  localparam int H_OP  = HALF - 1;
  localparam int H_PHY = H_OP - OP_W;
  localparam int H_REG = H_PHY - PHY_W;
  localparam int F_OP  = FRAME_W - 1;
  localparam int F_PHY = F_OP - OP_W;
  localparam int F_REG = F_PHY - PHY_W;

  logic [CNT_W-1:0]   cnt_q, cnt_inc, cnt_nxt;
  logic [FRAME_W-1:0] word_q, word_sh, word_nxt;
  logic               mdi_q, shift_in, all_ones, at_half, at_full, rd_go;
  logic [OP_W-1:0]    half_op, full_op;

  always_comb begin
    cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    shift_in = mdo_i && ((cnt_inc < HALF_C) || !dir_i);
    word_sh  = {word_q[FRAME_W-2:0], shift_in};
    all_ones = &word_sh;
    at_half  = !all_ones && (cnt_inc == HALF_C);
    at_full  = !all_ones && (cnt_inc == FULL_C);
    half_op  = word_sh[H_OP -: OP_W];
    full_op  = word_sh[F_OP -: OP_W];
    rd_go    = at_half && (half_op == OP_W'(OP_RD));
    cnt_nxt  = all_ones ? '0 : cnt_inc;
    word_nxt = rd_go ? {{(FRAME_W-DATA_W){1'b0}}, rd_data_i} : word_sh;
  end

  assign rd_phy_o  = word_sh[H_PHY -: PHY_W];
  assign rd_reg_o  = word_sh[H_REG -: ADDR_W];
  assign wr_phy_o  = word_sh[F_PHY -: PHY_W];
  assign wr_reg_o  = word_sh[F_REG -: ADDR_W];
  assign wr_data_o = word_sh[DATA_W-1:0];
  assign wr_en_o   = rise_i && at_full && (full_op == OP_W'(OP_WR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_q <= '0;
      mdi_q  <= 1'b0;
    end else if (rise_i) begin
      cnt_q  <= cnt_nxt;
      word_q <= word_nxt;
      // return line samples the shifted word before any register load
      if ((cnt_inc >= HALF_C) && dir_i) mdi_q <= word_sh[HALF-1];
    end
  end

  assign mdi_o = mdi_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> ($stable(cnt_q) && $stable(word_q))); // R1
  AST_PREAMBLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&word_q) |-> (cnt_q == '0)); // R3
  AST_MDI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && dir_i) |=> $stable(mdi_q)); // R5
endmodule

// File: rtl/mgmt_reg_file.sv
module mgmt_reg_file
  import mgmt_pkg::*;
#(
  parameter int N_REGS   = NUM_REGS,
  parameter int DATA_W   = REG_W,
  parameter int ADDR_W   = $clog2(N_REGS),
  parameter int PHY_W    = 5,
  parameter int PHY_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PHY_W-1:0]  rd_phy_i,
  input  logic [ADDR_W-1:0] rd_reg_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [PHY_W-1:0]  wr_phy_i,
  input  logic [ADDR_W-1:0] wr_reg_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam logic [PHY_W-1:0] MY_PHY = PHY_W'(PHY_ADDR);

  logic [DATA_W-1:0] regs_q [N_REGS];
  logic              wr_hit;

  assign wr_hit = wr_en_i && (wr_phy_i == MY_PHY);

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = DATA_W'(reg_mask(i));
    localparam logic [DATA_W-1:0] RSTV = DATA_W'(reg_reset(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[i] <= RSTV;
      else if (wr_hit && (wr_reg_i == ADDR_W'(i)))
        regs_q[i] <= (regs_q[i] & ~MASK) | (wr_data_i & MASK);
    end

    AST_RO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> ((regs_q[i] & ~MASK) == (RSTV & ~MASK))); // R8
    AST_FOREIGN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wr_phy_i != MY_PHY)) |=> $stable(regs_q[i])); // R7
  end

  always_comb begin
    rd_data_o = '0;
    if ((rd_phy_i == MY_PHY) && (int'(rd_reg_i) < N_REGS))
      rd_data_o = regs_q[rd_reg_i];
  end
endmodule

// File: rtl/mgmt_phy_slave.sv
module mgmt_phy_slave
  import mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PHY_ADDR    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  input  logic mdo_i,
  input  logic rd_dir_i,
  output logic mdi_o
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int PHY_W  = 5;

  logic [2:0]        sync_vec;
  logic              mdc_rise;
  logic [PHY_W-1:0]  rd_phy, wr_phy;
  logic [ADDR_W-1:0] rd_reg, wr_reg;
  logic [REG_W-1:0]  rd_data, wr_data;
  logic              wr_en;

  mgmt_edge_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({rd_dir_i, mdo_i, mdc_i}),
    .sync_o (sync_vec),
    .rise_o (mdc_rise)
  );

  mgmt_frame_shifter #(
    .FRAME_W(32), .OP_W(4), .PHY_W(PHY_W), .ADDR_W(ADDR_W),
    .DATA_W(REG_W), .OP_RD(6), .OP_WR(5)
  ) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (mdc_rise),
    .mdo_i    (sync_vec[1]),
    .dir_i    (sync_vec[2]),
    .rd_data_i(rd_data),
    .rd_phy_o (rd_phy),
    .rd_reg_o (rd_reg),
    .wr_en_o  (wr_en),
    .wr_phy_o (wr_phy),
    .wr_reg_o (wr_reg),
    .wr_data_o(wr_data),
    .mdi_o    (mdi_o)
  );

  mgmt_reg_file #(
    .N_REGS(NUM_REGS), .DATA_W(REG_W), .ADDR_W(ADDR_W),
    .PHY_W(PHY_W), .PHY_ADDR(PHY_ADDR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_phy_i (rd_phy),
    .rd_reg_i (rd_reg),
    .rd_data_o(rd_data),
    .wr_en_i  (wr_en),
    .wr_phy_i (wr_phy),
    .wr_reg_i (wr_reg),
    .wr_data_i(wr_data)
  );
endmodule

// File: tb/mgmt_phy_slave_tb_top.sv
module mgmt_phy_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0, mdo = 1'b0, rd_dir = 1'b0;
  logic mdi;
  logic last_mdi;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  mgmt_phy_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mdc_i(mdc), .mdo_i(mdo),
    .rd_dir_i(rd_dir), .mdi_o(mdi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, input logic dir);
    mdo = b; rd_dir = dir;
    repeat (4) @(negedge clk);
    mdc = 1'b1;
    repeat (8) @(negedge clk);
    last_mdi = mdi;
    mdc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic preamble();
    for (int i = 0; i < 32; i++) clk_bit(1'b1, 1'b0);
  endtask

  // frame = {ST+op nibble, phy, reg, turnaround, data}; optional idle noise after bit 20
  task automatic write_frame(input logic [4:0] phy, input logic [4:0] rn,
                             input logic [15:0] data, input logic [3:0] op_nib,
                             input bit idle_mid);
    logic [31:0] f;
    logic        held;
    int          moved;
    f = {op_nib, phy, rn, 2'b10, data};
    preamble();
    held = mdi; moved = 0;
    for (int i = 31; i >= 0; i--) begin
      clk_bit(f[i], 1'b0);
      if (last_mdi !== held) moved++;
      if (idle_mid && i == 12) begin
        for (int k = 0; k < 40; k++) begin
          mdo = k[0]; rd_dir = k[1];
          @(negedge clk);
          if (mdi !== held) moved++;
        end
        rd_dir = 1'b0;
      end
    end
    check("R5 mdi held while direction low", moved, 0);
  endtask

  task automatic read_frame(input logic [4:0] phy, input logic [4:0] rn,
                            output logic [14:0] got, output logic tail);
    logic [15:0] h;
    h = {4'b0110, phy, rn, 2'b10};
    preamble();
    for (int i = 15; i >= 0; i--) clk_bit(h[i], 1'b0);
    for (int j = 0; j < 16; j++) begin
      clk_bit(1'b1, 1'b1); // ones on data line must not enter the word
      if (j < 15) got[14-j] = last_mdi;
      else        tail = last_mdi;
    end
    rd_dir = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [4:0] phy,
                            input logic [4:0] rn, input logic [15:0] exp);
    logic [14:0] got;
    logic        tail;
    read_frame(phy, rn, got, tail);
    check(req, {17'd0, got}, {17'd0, exp[14:0]});
    check("R2 zero shifted in during read data phase", {31'd0, tail}, 32'd0);
  endtask

  task automatic t_reset();
    check("R5 mdi zero after reset", {31'd0, mdi}, 32'd0);
  endtask

  task automatic t_defaults();
    expect_reg("R9 reg0 default (R4 read)", 5'd1, 5'd0, 16'h3100);
    expect_reg("R9 reg1 default", 5'd1, 5'd1, 16'hF02C);
    expect_reg("R9 reg2 default", 5'd1, 5'd2, 16'h7810);
    expect_reg("R9 reg3 default", 5'd1, 5'd3, 16'h0000);
    expect_reg("R9 reg4 default", 5'd1, 5'd4, 16'h0501);
    expect_reg("R9 reg5 default", 5'd1, 5'd5, 16'h4181);
    expect_reg("R9 reg16 default", 5'd1, 5'd16, 16'h0003);
    expect_reg("R9 reg18 default", 5'd1, 5'd18, 16'h0001);
  endtask

  task automatic t_full_write();
    write_frame(5'd1, 5'd3, 16'h1234, 4'b0101, 1'b0);
    expect_reg("R6 write reg3", 5'd1, 5'd3, 16'h1234);
    write_frame(5'd1, 5'd20, 16'h2BCD, 4'b0101, 1'b0);
    expect_reg("R6 write reg20", 5'd1, 5'd20, 16'h2BCD);
  endtask

  task automatic t_masks();
    write_frame(5'd1, 5'd4, 16'hFFFF, 4'b0101, 1'b0);
    expect_reg("R8 reg4 mask C01F", 5'd1, 5'd4, 16'hC51F);
    write_frame(5'd1, 5'd0, 16'h0000, 4'b0101, 1'b0);
    expect_reg("R8 reg0 read-only", 5'd1, 5'd0, 16'h3100);
    write_frame(5'd1, 5'd16, 16'hFFFF, 4'b0101, 1'b0);
    expect_reg("R8 reg16 mask 0FFF", 5'd1, 5'd16, 16'h0FFF);
    write_frame(5'd1, 5'd7, 16'h2BCD, 4'b0101, 1'b0);
    expect_reg("R8 reg7 read-only", 5'd1, 5'd7, 16'h0000);
    write_frame(5'd1, 5'd26, 16'h7777, 4'b0101, 1'b0);
    expect_reg("R8 reg26 read-only", 5'd1, 5'd26, 16'h0000);
  endtask

  task automatic t_foreign();
    write_frame(5'd2, 5'd3, 16'h0F0F, 4'b0101, 1'b0);
    expect_reg("R7 write to phy 2 ignored", 5'd1, 5'd3, 16'h1234);
    expect_reg("R7 read of phy 0 returns zero", 5'd0, 5'd1, 16'h0000);
  endtask

  task automatic t_bad_op();
    write_frame(5'd1, 5'd2, 16'h0AAA, 4'b0111, 1'b0);
    expect_reg("R10 unknown opcode ignored", 5'd1, 5'd2, 16'h7810);
  endtask

  task automatic t_idle();
    write_frame(5'd1, 5'd5, 16'h1357, 4'b0101, 1'b1);
    expect_reg("R1 idle toggles leave frame intact", 5'd1, 5'd5, 16'h1357);
  endtask

  task automatic t_resync();
    for (int i = 0; i < 7; i++) clk_bit(i[0], 1'b0);
    write_frame(5'd1, 5'd6, 16'h2468, 4'b0101, 1'b0);
    expect_reg("R3 preamble realigns after junk", 5'd1, 5'd6, 16'h2468);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_defaults();
    t_full_write();
    t_masks();
    t_foreign();
    t_bad_op();
    t_idle();
    t_resync();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule